// File: doc/BRIEF.md
# Selectable VGA Colour Output Formatter

This block is the final stage in front of the colour pins of a small VGA video source. Each pixel clock it takes a 6-bit colour (2 bits for each of red, green and blue), the low bits of the pixel position and the frame counter, a flag marking the visible area, a speaker bit and the two sync lines. From these it drives the colour pins in one of three formats. The plain format sends the top bit of each channel to three pins. The dither format also uses three pins, but it approximates the two middle levels of every channel with an ordered pattern that changes with pixel position and frame. The deep format drives all six colour bits, and the speaker pin carries the blue low bit.

The format comes from a 2-bit select input. A new select value is taken up only when a frame begins, which is the cycle in which the vertical sync line enters its active level, so no frame shows two formats. All outputs, including the two sync lines, leave through one register stage, which keeps colour and sync aligned. Colour is forced to zero whenever the pixel lies outside the visible area. The block has no back-pressure. It produces one pixel on every clock, so its edge has no valid/ready handshake.

Top module: `vga_colour_fmt`

## Requirements
- R1: While reset is asserted and until the first clock after it, every colour pin and the speaker pin are 0 and both sync outputs are at their inactive level (high with the default active-low sync). The active format is plain (code 0).
- R2: In format code 0 the colour pins `rgb_msb[2:0]` carry `{pix_rgb[5], pix_rgb[3], pix_rgb[1]}` (red, green, blue top bits). `rgb_lsb_rg` is 0 and `spk_pin` carries `spk_in`.
- R3: In format code 1, each channel level L (red `pix_rgb[5:4]`, green `[3:2]`, blue `[1:0]`) drives its `rgb_msb` bit through an ordered dither. The pattern index i = (2*pos_y[0] + pos_x[0]) XOR frame_cnt[1:0] selects a threshold T from 0, 2, 3, 1 for i = 0, 1, 2, 3. The output is 1 when L > T or L = 3. `rgb_lsb_rg` is 0 and `spk_pin` carries `spk_in`.
- R4: In format code 1, at any one pixel position over four consecutive frame counts, level 0 is never lit, level 1 is lit once, level 2 is lit twice and level 3 is lit all four times.
- R5: In format code 2, `rgb_msb` carries the channel top bits as in R2, `rgb_lsb_rg` carries `{pix_rgb[4], pix_rgb[2]}` and `spk_pin` carries the blue low bit `pix_rgb[0]` instead of the speaker.
- R6: When `visible` is 0, all of `rgb_msb`, `rgb_lsb_rg` and, in format code 2, `spk_pin` are 0. In codes 0, 1 and 3 the speaker still passes through.
- R7: `hsync_out` and `vsync_out` equal `hsync_in` and `vsync_in` of the previous clock, in every format.
- R8: `mode_sel` is loaded into the active format only on a clock where `vsync_in` is at its active level and was inactive on the clock before. A change of `mode_sel` at any other time has no effect on the outputs.
- R9: Format code 3 behaves exactly as format code 0.
- R10: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested format: 0 plain, 1 dither, 2 deep, 3 same as 0 |
| pix_rgb | input | 6 | Pixel colour {R1,R0,G1,G0,B1,B0} |
| pos_x | input | XW | Pixel column (bit 0 used) |
| pos_y | input | YW | Pixel row (bit 0 used) |
| frame_cnt | input | FW | Frame counter (bits 1:0 used) |
| visible | input | 1 | High inside the visible area |
| spk_in | input | 1 | Speaker bit |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| rgb_msb | output | 3 | Main colour pins {R,G,B} |
| rgb_lsb_rg | output | 2 | Red and green low bits (deep format only) |
| spk_pin | output | 1 | Speaker, or blue low bit in deep format |
| hsync_out | output | 1 | Registered horizontal sync |
| vsync_out | output | 1 | Registered vertical sync |

## Verification
Every colour, speaker and sync output is due exactly one rising edge after the inputs that produce it. A format change is due on the first pixel presented after the edge that sees vertical sync become active. The bench sets inputs on the falling edge and compares all eight output bits on the next falling edge, so each comparison covers exactly one register stage. It also probes once just before a rising edge to show that the old pixel is still held. Format changes are made with an explicit sync pulse and take effect only from the following pixel, which the bench accounts for. Stray select changes are made while vertical sync is held active, where no edge occurs.

// File: rtl/vgafmt_pkg.sv
package vgafmt_pkg;

  typedef enum logic [1:0] {
    FMT_PLAIN  = 2'd0,
    FMT_DITHER = 2'd1,
    FMT_DEEP   = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  localparam int unsigned CHANNELS = 3;
  localparam int unsigned CH_BITS  = 2;
  localparam int unsigned PIX_W    = CHANNELS * CH_BITS;

  // Ordered 2x2 threshold for a given pattern index.
  function automatic logic [1:0] bayer_thr(input logic [1:0] idx);
    case (idx)
      2'd0:    bayer_thr = 2'd0;
      2'd1:    bayer_thr = 2'd2;
      2'd2:    bayer_thr = 2'd3;
      default: bayer_thr = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/vgafmt_mode_latch.sv
module vgafmt_mode_latch
  import vgafmt_pkg::*;
#(
  parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_in,
  input  logic [1:0] mode_sel,
  output fmt_e       mode_act
);
  localparam logic VS_ON = SYNC_ACTIVE_HIGH;

  logic vs_prev;
  logic frame_start;

  assign frame_start = (vsync_in == VS_ON) && (vs_prev != VS_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_prev  <= ~VS_ON;
      mode_act <= FMT_PLAIN;
    end else begin
      vs_prev <= vsync_in;
      if (frame_start) mode_act <= fmt_e'(mode_sel);
    end
  end

  // R8: active format only changes on a frame start
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_act));

endmodule

// File: rtl/vgafmt_dither.sv
module vgafmt_dither
  import vgafmt_pkg::*;
(
  input  logic [CH_BITS-1:0] level,
  input  logic [1:0]         phase,
  output logic               lit
);
  logic [1:0] thr;

  always_comb begin
    thr = bayer_thr(phase);
    lit = (level == 2'd3) || (level > thr);
  end

endmodule

// File: rtl/vgafmt_colour_map.sv
module vgafmt_colour_map
  import vgafmt_pkg::*;
(
  input  fmt_e               mode,
  input  logic [PIX_W-1:0]   pix,
  input  logic [1:0]         phase,
  output logic [CHANNELS-1:0] msb,
  output logic [1:0]         lsb_rg,
  output logic               blue_lsb,
  output logic               deep
);
  logic [CHANNELS-1:0] top_bit;
  logic [CHANNELS-1:0] dith_bit;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    assign top_bit[ch] = pix[CH_BITS*ch + 1];
    vgafmt_dither u_dither (
      .level (pix[CH_BITS*ch +: CH_BITS]),
      .phase (phase),
      .lit   (dith_bit[ch])
    );
  end

  always_comb begin
    deep     = (mode == FMT_DEEP);
    msb      = (mode == FMT_DITHER) ? dith_bit : top_bit;
    lsb_rg   = deep ? {pix[4], pix[2]} : 2'b00;
    blue_lsb = pix[0];
  end

endmodule

// File: rtl/vgafmt_out_stage.sv
module vgafmt_out_stage
  import vgafmt_pkg::*;
#(
  parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                visible,
  input  logic                deep,
  input  logic [CHANNELS-1:0] msb,
  input  logic [1:0]          lsb_rg,
  input  logic                blue_lsb,
  input  logic                spk_in,
  input  logic                hsync_in,
  input  logic                vsync_in,
  output logic [CHANNELS-1:0] rgb_msb,
  output logic [1:0]          rgb_lsb_rg,
  output logic                spk_pin,
  output logic                hsync_out,
  output logic                vsync_out
);
  localparam logic SYNC_IDLE = ~SYNC_ACTIVE_HIGH;

  logic started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_msb    <= '0;
      rgb_lsb_rg <= '0;
      spk_pin    <= 1'b0;
      hsync_out  <= SYNC_IDLE;
      vsync_out  <= SYNC_IDLE;
      started    <= 1'b0;
    end else begin
      rgb_msb    <= visible ? msb : '0;
      rgb_lsb_rg <= visible ? lsb_rg : 2'b00;
      spk_pin    <= deep ? (visible & blue_lsb) : spk_in;
      hsync_out  <= hsync_in;
      vsync_out  <= vsync_in;
      started    <= 1'b1;
    end
  end

  // R6: blanked pixel leaves all colour pins dark
  a_r6_blank: assert property (@(posedge clk) disable iff (!rst_n)
    started && !$past(visible) |-> (rgb_msb == '0) && (rgb_lsb_rg == 2'b00));

endmodule

// File: rtl/vga_colour_fmt.sv
module vga_colour_fmt
  import vgafmt_pkg::*;
#(
  parameter int unsigned XW = 10,
  parameter int unsigned YW = 10,
  parameter int unsigned FW = 4,
  parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic [5:0]    pix_rgb,
  input  logic [XW-1:0] pos_x,
  input  logic [YW-1:0] pos_y,
  input  logic [FW-1:0] frame_cnt,
  input  logic          visible,
  input  logic          spk_in,
  input  logic          hsync_in,
  input  logic          vsync_in,
  output logic [2:0]    rgb_msb,
  output logic [1:0]    rgb_lsb_rg,
  output logic          spk_pin,
  output logic          hsync_out,
  output logic          vsync_out
);
  fmt_e                mode_act;
  logic [1:0]          phase;
  logic [CHANNELS-1:0] map_msb;
  logic [1:0]          map_lsb;
  logic                map_blue_lsb;
  logic                map_deep;
  logic                past_ok;
  logic                unused_pos;

  assign phase      = {pos_y[0], pos_x[0]} ^ frame_cnt[1:0];
  assign unused_pos = ^{pos_x, pos_y, frame_cnt};

  vgafmt_mode_latch #(.SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync_in (vsync_in),
    .mode_sel (mode_sel),
    .mode_act (mode_act)
  );

  vgafmt_colour_map u_map (
    .mode     (mode_act),
    .pix      (pix_rgb),
    .phase    (phase),
    .msb      (map_msb),
    .lsb_rg   (map_lsb),
    .blue_lsb (map_blue_lsb),
    .deep     (map_deep)
  );

  vgafmt_out_stage #(.SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .visible    (visible),
    .deep       (map_deep),
    .msb        (map_msb),
    .lsb_rg     (map_lsb),
    .blue_lsb   (map_blue_lsb),
    .spk_in     (spk_in),
    .hsync_in   (hsync_in),
    .vsync_in   (vsync_in),
    .rgb_msb    (rgb_msb),
    .rgb_lsb_rg (rgb_lsb_rg),
    .spk_pin    (spk_pin),
    .hsync_out  (hsync_out),
    .vsync_out  (vsync_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7: sync lines are delayed by exactly one clock
  a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (hsync_out == $past(hsync_in)) && (vsync_out == $past(vsync_in)));

  // R5: in deep format the speaker pin carries the gated blue low bit
  a_r5_spk_lane: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_act == FMT_DEEP) |-> spk_pin == $past(visible & pix_rgb[0]));

  // R4: full red level always lit in dither format
  a_r4_full_lit: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_act == FMT_DITHER && visible && pix_rgb[5:4] == 2'b11)
    |-> rgb_msb[2]);

  // R4: zero red level never lit in dither format
  a_r4_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode_act == FMT_DITHER && pix_rgb[5:4] == 2'b00)
    |-> !rgb_msb[2]);

endmodule

// File: tb/test_vga_colour_fmt.sv
module test_vga_colour_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [5:0] pix_rgb = '0;
  logic [9:0] pos_x = '0;
  logic [9:0] pos_y = '0;
  logic [3:0] frame_cnt = '0;
  logic       visible = 1'b0;
  logic       spk_in = 1'b0;
  logic       hsync_in = 1'b1;
  logic       vsync_in = 1'b1;
  logic [2:0] rgb_msb;
  logic [1:0] rgb_lsb_rg;
  logic       spk_pin;
  logic       hsync_out;
  logic       vsync_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vga_colour_fmt i_vga_colour_fmt (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pix_rgb(pix_rgb),
    .pos_x(pos_x), .pos_y(pos_y), .frame_cnt(frame_cnt), .visible(visible),
    .spk_in(spk_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .rgb_msb(rgb_msb), .rgb_lsb_rg(rgb_lsb_rg), .spk_pin(spk_pin),
    .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  function automatic logic [7:0] got_vec();
    return {rgb_msb, rgb_lsb_rg, spk_pin, hsync_out, vsync_out};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  function automatic logic dith(input logic [1:0] lvl, input logic [1:0] idx);
    int thr;
    thr = (idx == 0) ? 0 : (idx == 1) ? 2 : (idx == 2) ? 3 : 1;
    return (lvl == 2'd3) || (int'(lvl) > thr);
  endfunction

  function automatic logic [7:0] model(input int m, input logic [5:0] p, input logic x0,
                                       input logic y0, input logic [1:0] f, input logic vis,
                                       input logic spk, input logic hs, input logic vs);
    logic [2:0] msb;
    logic [1:0] lsb;
    logic       sp;
    logic [1:0] idx;
    idx = {y0, x0} ^ f;
    msb = {p[5], p[3], p[1]};
    lsb = 2'b00;
    sp  = spk;
    if (m == 1) msb = {dith(p[5:4], idx), dith(p[3:2], idx), dith(p[1:0], idx)};
    if (m == 2) begin
      lsb = {p[4], p[2]};
      sp  = vis & p[0];
    end
    if (!vis) begin
      msb = 3'b000;
      lsb = 2'b00;
    end
    return {msb, lsb, sp, hs, vs};
  endfunction

  task automatic drive(input logic [5:0] p, input logic x0, input logic y0, input logic [1:0] f,
                       input logic vis, input logic spk, input logic hs);
    pix_rgb   = p;
    pos_x     = {9'd5, x0};
    pos_y     = {9'd7, y0};
    frame_cnt = {2'b10, f};
    visible   = vis;
    spk_in    = spk;
    hsync_in  = hs;
  endtask

  // Frame start: vsync goes active (low) for one clock; new format applies after it.
  task automatic set_mode(input logic [1:0] m);
    mode_sel = m;
    vsync_in = 1'b0;
    @(negedge clk);
    vsync_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic sweep(input int m, input string req);
    for (int p = 0; p < 64; p++)
      for (int pos = 0; pos < 4; pos++)
        for (int f = 0; f < 4; f++)
          for (int v = 0; v < 2; v++) begin
            logic x0, y0, spk, hs;
            x0  = pos[0];
            y0  = pos[1];
            spk = p[4] ^ y0 ^ f[0];
            hs  = p[2] ^ x0;
            drive(6'(p), x0, y0, 2'(f), v[0], spk, hs);
            @(negedge clk);
            check(v[0] ? req : "R6", got_vec(),
                  model(m, 6'(p), x0, y0, 2'(f), v[0], spk, hs, vsync_in));
          end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int cnt;
    repeat (3) @(negedge clk);
    // R1: reset state, colour dark, sync idle high
    check("R1", got_vec(), 8'b000_00_0_1_1);
    drive(6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: active format after reset is plain
    check("R1", got_vec(), model(0, 6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1));

    // R10: output holds the old pixel until the next rising edge
    drive(6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
    #5;
    check("R10", got_vec(), model(0, 6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1));
    @(negedge clk);
    check("R10", got_vec(), model(0, 6'h00, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1));

    sweep(0, "R2");

    // R7: vsync pass-through over the frame-start pulse
    drive(6'h15, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1);
    mode_sel = 2'd1;
    vsync_in = 1'b0;
    @(negedge clk);
    check("R7", got_vec(), model(0, 6'h15, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0));
    vsync_in = 1'b1;
    @(negedge clk);
    check("R7", got_vec(), model(1, 6'h15, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1));

    sweep(1, "R3");

    // R4: duty over four frames at one position
    for (int lvl = 0; lvl < 4; lvl++) begin
      cnt = 0;
      for (int f = 0; f < 4; f++) begin
        drive({2'(lvl), 4'b0000}, 1'b1, 1'b0, 2'(f), 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        cnt += int'(rgb_msb[2]);
      end
      check("R4", 8'(cnt), 8'((lvl == 3) ? 4 : lvl));
    end

    // R8: select change without a vsync edge is ignored (vsync held active)
    vsync_in = 1'b0;
    drive(6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    mode_sel = 2'd2;
    drive(6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check("R8", got_vec(), model(1, 6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0));
    vsync_in = 1'b1;
    @(negedge clk);
    check("R8", got_vec(), model(1, 6'h3F, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1));

    set_mode(2'd2);
    sweep(2, "R5");

    set_mode(2'd3);
    sweep(3, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule